// File: doc/BRIEF.md
# Character Display Command Receiver (4-bit bus)

This block models the display side of a character display controller whose host talks to it over a reduced four-line data bus. It watches the enable strobe and captures the register-select line and the four data lines when enable falls. It pairs two nibble transfers into one byte, with the upper nibble first. The single exception is the very first strobe after reset, which is taken on its own as a complete command. Each completed byte is either an instruction (select low) or a character (select high).

Instructions are classified by the position of their highest set bit. They update the controller's visible state: the character memory address, the glyph memory address and which of the two is selected, the entry direction and auto-shift, the display, cursor and blink flags, the line count and the font, and a view offset that follows display shifts. Characters are written into an internal character memory of 2^AW bytes, and a peek port reads that memory back. Each accepted byte starts a busy period counted in microsecond ticks. A strobe that arrives while busy is discarded and counted.

Top module: `chlcd_rx`

## Requirements
- R1: After reset the block is not busy. Both addresses and the view offset are 0, the glyph memory is not selected, and increment mode is on (inc_mode=1). Auto-shift, display, cursor, blink, two_lines and tall_font are all 0. wide_bus is 1, the error count is 0 and every character memory byte holds 0x20.
- R2: The first falling edge of lcd_en after reset completes a byte by itself. That byte is {lcd_d, 4'h0}, so a nibble of 0x3 acts as the instruction 0x30 (function set with the wide-bus bit set). Every later byte needs two strobes.
- R3: Each later byte is {first nibble, second nibble}, both sampled from lcd_d on the falling edge of lcd_en. lcd_rs sampled at the second strobe marks an instruction (0) or a character (1).
- R4: An instruction is classified by its highest set bit. Bit 7 sets the character address to bits 6:0 and deselects the glyph memory. Bit 6 sets the glyph address to bits 5:0 and selects the glyph memory. Bit 5 is function set. Bit 4 is cursor/display shift. Bit 3 is display control. Bit 2 is entry mode. Bit 1 is return home. Bit 0 alone is clear. The lower bits of each instruction are its operands.
- R5: Clear and return home hold busy for LONG_TICKS ticks. Every other instruction, and every character write, holds it for SHORT_TICKS ticks. The all-zero instruction changes nothing and starts no busy period.
- R6: Entry mode copies bit 1 to inc_mode and bit 0 to shift_mode. A character write stores the byte at the current character address, then steps that address by +1 (inc_mode=1) or −1, wrapping modulo 2^AW. With shift_mode=1 it also steps view_offset in the same direction.
- R7: Display control copies bit 2 to display_on, bit 1 to cursor_on and bit 0 to blink_on.
- R8: Function set copies bit 4 to wide_bus and bit 3 to two_lines. tall_font takes bit 2 only when bit 3 is 0 and is 0 otherwise. The transfer format stays two strobes whatever wide_bus holds.
- R9: Clear fills the character memory with 0x20, zeroes the character address and view offset, deselects the glyph memory and sets inc_mode. Return home zeroes the character address and view offset, deselects the glyph memory and leaves the memory contents alone.
- R10: Cursor/display shift with bit 3 = 0 steps the character address. With bit 3 = 1 it steps view_offset. Bit 2 set means +1 and clear means −1.
- R11: While the glyph memory is selected, a character write steps cgram_addr (6 bits, wrapping) by the entry direction. It leaves the character memory and its address unchanged.
- R12: A falling edge of lcd_en while busy changes no state and does not advance the nibble pairing. It increments strobe_errs, which saturates at its all-ones value.
- R13: The busy count decreases only in cycles where us_tick is high. busy stays low until a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lcd_en | input | 1 | Enable strobe from the host; data taken on its falling edge |
| lcd_rs | input | 1 | Register select: 0 instruction, 1 character |
| lcd_d | input | 4 | Nibble data lines |
| peek_addr | input | AW | Character memory read address |
| peek_data | output | 8 | Character memory byte at peek_addr |
| busy | output | 1 | Instruction or write still executing |
| ddram_addr | output | AW | Current character memory address |
| cgram_addr | output | 6 | Current glyph memory address |
| cg_select | output | 1 | Character writes target glyph memory |
| inc_mode | output | 1 | Entry direction, 1 = increment |
| shift_mode | output | 1 | Auto-shift of the view on writes |
| display_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Blinking cursor |
| wide_bus | output | 1 | Recorded bus-width bit of function set |
| two_lines | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall font in effect |
| view_offset | output | AW | Display shift position |
| strobe_errs | output | ERR_W | Saturating count of strobes refused while busy |

## Verification
The assertions assume the host holds lcd_rs and lcd_d stable across the clock edge where lcd_en is seen low after being high. They also assume us_tick is a single-cycle pulse. The bench drives every input change at the falling clock edge, and it keeps data and select steady for the enable-high cycles, the falling cycle and one cycle after. Strobes during busy periods are issued on purpose to exercise the refusal path. Otherwise the bench waits for busy to drop before the next transfer.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR, OP_DATA
  } op_e;

  // Highest set bit selects the instruction class; select=1 means data.
  function automatic op_e classify(input logic sel, input logic [7:0] b);
    if (sel)  return OP_DATA;
    if (b[7]) return OP_DDADDR;
    if (b[6]) return OP_CGADDR;
    if (b[5]) return OP_FUNC;
    if (b[4]) return OP_SHIFT;
    if (b[3]) return OP_DISP;
    if (b[2]) return OP_ENTRY;
    if (b[1]) return OP_HOME;
    if (b[0]) return OP_CLEAR;
    return OP_NONE;
  endfunction

  function automatic int unsigned busy_ticks(input op_e op,
                                             input int unsigned long_t,
                                             input int unsigned short_t);
    case (op)
      OP_NONE:           return 0;
      OP_CLEAR, OP_HOME: return long_t;
      default:           return short_t;
    endcase
  endfunction

endpackage

// File: rtl/chlcd_nib_join.sv
module chlcd_nib_join (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rs,
  input  logic [3:0] d,
  input  logic       block,
  output logic       byte_vld,
  output logic       byte_rs,
  output logic [7:0] byte_val,
  output logic       strobe_ign
);
  logic       en_q;
  logic       first_pend;
  logic       phase;
  logic [3:0] hi_nib;
  logic       fall;
  logic       take;

  always_comb begin
    fall       = en_q & ~en;
    take       = fall & ~block;
    strobe_ign = fall & block;
    byte_vld   = take & (first_pend | phase);
    byte_rs    = rs;
    byte_val   = first_pend ? {d, 4'h0} : {hi_nib, d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      first_pend <= 1'b1;
      phase      <= 1'b0;
      hi_nib     <= '0;
    end else begin
      en_q <= en;
      if (take) begin
        if (first_pend) begin
          first_pend <= 1'b0;
          phase      <= 1'b0;
        end else if (!phase) begin
          hi_nib <= d;
          phase  <= 1'b1;
        end else begin
          phase <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/chlcd_busy_tmr.sv
module chlcd_busy_tmr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/chlcd_rx.sv
module chlcd_rx
  import chlcd_pkg::*;
#(
  parameter int AW          = 7,
  parameter int LONG_TICKS  = 1520,
  parameter int SHORT_TICKS = 37,
  parameter int ERR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             lcd_en,
  input  logic             lcd_rs,
  input  logic [3:0]       lcd_d,
  input  logic [AW-1:0]    peek_addr,
  output logic [7:0]       peek_data,
  output logic             busy,
  output logic [AW-1:0]    ddram_addr,
  output logic [5:0]       cgram_addr,
  output logic             cg_select,
  output logic             inc_mode,
  output logic             shift_mode,
  output logic             display_on,
  output logic             cursor_on,
  output logic             blink_on,
  output logic             wide_bus,
  output logic             two_lines,
  output logic             tall_font,
  output logic [AW-1:0]    view_offset,
  output logic [ERR_W-1:0] strobe_errs
);
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  // Named internal events, also used by the bound checker.
  logic             byte_vld;
  logic             byte_rs;
  logic [7:0]       byte_val;
  logic             strobe_ign;
  op_e              byte_op;
  logic             load_busy;
  logic [CNT_W-1:0] load_val;

  logic [7:0] mem [DEPTH];

  function automatic logic [AW-1:0] nudge(input logic [AW-1:0] a, input logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  chlcd_nib_join u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (lcd_en),
    .rs         (lcd_rs),
    .d          (lcd_d),
    .block      (busy),
    .byte_vld   (byte_vld),
    .byte_rs    (byte_rs),
    .byte_val   (byte_val),
    .strobe_ign (strobe_ign)
  );

  always_comb begin
    byte_op   = classify(byte_rs, byte_val);
    load_busy = byte_vld && (byte_op != OP_NONE);
    load_val  = CNT_W'(busy_ticks(byte_op, LONG_TICKS, SHORT_TICKS));
  end

  chlcd_busy_tmr #(.CNT_W(CNT_W)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .load     (load_busy),
    .load_val (load_val),
    .busy     (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h20;
      ddram_addr  <= '0;
      cgram_addr  <= '0;
      cg_select   <= 1'b0;
      inc_mode    <= 1'b1;
      shift_mode  <= 1'b0;
      display_on  <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      wide_bus    <= 1'b1;
      two_lines   <= 1'b0;
      tall_font   <= 1'b0;
      view_offset <= '0;
    end else if (byte_vld) begin
      case (byte_op)
        OP_CLEAR: begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h20;
          ddram_addr  <= '0;
          view_offset <= '0;
          cg_select   <= 1'b0;
          inc_mode    <= 1'b1;
        end
        OP_HOME: begin
          ddram_addr  <= '0;
          view_offset <= '0;
          cg_select   <= 1'b0;
        end
        OP_ENTRY: begin
          inc_mode   <= byte_val[1];
          shift_mode <= byte_val[0];
        end
        OP_DISP: begin
          display_on <= byte_val[2];
          cursor_on  <= byte_val[1];
          blink_on   <= byte_val[0];
        end
        OP_SHIFT: begin
          if (byte_val[3]) view_offset <= nudge(view_offset, byte_val[2]);
          else             ddram_addr  <= nudge(ddram_addr, byte_val[2]);
        end
        OP_FUNC: begin
          wide_bus  <= byte_val[4];
          two_lines <= byte_val[3];
          tall_font <= byte_val[2] & ~byte_val[3];
        end
        OP_CGADDR: begin
          cgram_addr <= byte_val[5:0];
          cg_select  <= 1'b1;
        end
        OP_DDADDR: begin
          ddram_addr <= byte_val[AW-1:0];
          cg_select  <= 1'b0;
        end
        OP_DATA: begin
          if (cg_select) begin
            cgram_addr <= inc_mode ? cgram_addr + 1'b1 : cgram_addr - 1'b1;
          end else begin
            mem[ddram_addr] <= byte_val;
            ddram_addr      <= nudge(ddram_addr, inc_mode);
            if (shift_mode) view_offset <= nudge(view_offset, inc_mode);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             strobe_errs <= '0;
    else if (strobe_ign && strobe_errs != '1) strobe_errs <= strobe_errs + 1'b1;
  end

  assign peek_data = mem[peek_addr];
endmodule

// File: rtl/chlcd_rx_chk.sv
module chlcd_rx_chk
  import chlcd_pkg::*;
#(
  parameter int AW    = 7,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             byte_vld,
  input logic             strobe_ign,
  input op_e              byte_op,
  input logic             cg_select,
  input logic             inc_mode,
  input logic [AW-1:0]    ddram_addr,
  input logic [ERR_W-1:0] strobe_errs
);
  // R12: the assembler never hands over a byte while the timer runs
  a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !busy);

  // R5: every real instruction or write starts a busy period
  a_r5_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_op != OP_NONE) |=> busy);

  // R13: busy cannot rise without an accepted byte
  a_r13_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !byte_vld) |=> !busy);

  // R12: refused strobe bumps the error count until saturation
  a_r12_err_count: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ign && strobe_errs != '1) |=> strobe_errs == ERR_W'($past(strobe_errs) + 1'b1));

  // R12: refused strobe leaves the address alone
  a_r12_ignored_addr: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ign |=> $stable(ddram_addr));

  // R9: clear returns the address to zero in increment mode
  a_r9_clear_home: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_op == OP_CLEAR) |=> (ddram_addr == '0 && inc_mode));

  // R6: character write in increment mode advances the address by one
  a_r6_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_op == OP_DATA && !cg_select && inc_mode)
      |=> ddram_addr == AW'($past(ddram_addr) + 1'b1));
endmodule

bind chlcd_rx chlcd_rx_chk #(.AW(AW), .ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .byte_vld    (byte_vld),
  .strobe_ign  (strobe_ign),
  .byte_op     (byte_op),
  .cg_select   (cg_select),
  .inc_mode    (inc_mode),
  .ddram_addr  (ddram_addr),
  .strobe_errs (strobe_errs)
);

// File: tb/chlcd_rx_test.sv
`timescale 1ns/1ps
module chlcd_rx_test;
  localparam int AW = 7;
  localparam int LT = 1520;
  localparam int ST = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       lcd_en = 1'b0;
  logic       lcd_rs = 1'b0;
  logic [3:0] lcd_d = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [7:0] peek_data;
  logic       busy, cg_select, inc_mode, shift_mode, display_on, cursor_on;
  logic       blink_on, wide_bus, two_lines, tall_font;
  logic [AW-1:0] ddram_addr, view_offset;
  logic [5:0] cgram_addr;
  logic [7:0] strobe_errs;

  always #10 clk = ~clk;

  chlcd_rx #(.AW(AW), .LONG_TICKS(LT), .SHORT_TICKS(ST), .ERR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .lcd_en(lcd_en),
    .lcd_rs(lcd_rs), .lcd_d(lcd_d), .peek_addr(peek_addr), .peek_data(peek_data),
    .busy(busy), .ddram_addr(ddram_addr), .cgram_addr(cgram_addr),
    .cg_select(cg_select), .inc_mode(inc_mode), .shift_mode(shift_mode),
    .display_on(display_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .wide_bus(wide_bus), .two_lines(two_lines), .tall_font(tall_font),
    .view_offset(view_offset), .strobe_errs(strobe_errs)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural reference state
  int m_mem [128];
  int m_addr, m_cg, m_sel, m_inc, m_sh, m_don, m_con, m_bon, m_wide, m_two, m_tall;
  int m_view, m_err, m_busy, m_first, m_half, m_hi, m_enq;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int wrap7(input int v);
    return (v + 128) % 128;
  endfunction

  task automatic model_reset();
    foreach (m_mem[k]) m_mem[k] = 32;
    m_addr = 0; m_cg = 0; m_sel = 0; m_inc = 1; m_sh = 0; m_don = 0; m_con = 0;
    m_bon = 0; m_wide = 1; m_two = 0; m_tall = 0; m_view = 0; m_err = 0;
    m_busy = 0; m_first = 1; m_half = 0; m_hi = 0; m_enq = 0;
  endtask

  // returns the busy length the byte starts
  function automatic int model_apply(input int rs, input int b);
    int top = -1;
    int dir;
    if (rs == 1) begin
      dir = m_inc ? 1 : -1;
      if (m_sel == 1) m_cg = (m_cg + dir + 64) % 64;
      else begin
        m_mem[m_addr] = b;
        m_addr = wrap7(m_addr + dir);
        if (m_sh == 1) m_view = wrap7(m_view + dir);
      end
      return ST;
    end
    for (int k = 7; k >= 0; k--) if (((b >> k) & 1) == 1) begin top = k; break; end
    case (top)
      -1: return 0;
      0: begin foreach (m_mem[k]) m_mem[k] = 32; m_addr = 0; m_view = 0; m_sel = 0; m_inc = 1; return LT; end
      1: begin m_addr = 0; m_view = 0; m_sel = 0; return LT; end
      2: begin m_inc = (b >> 1) & 1; m_sh = b & 1; end
      3: begin m_don = (b >> 2) & 1; m_con = (b >> 1) & 1; m_bon = b & 1; end
      4: begin
        dir = ((b >> 2) & 1) ? 1 : -1;
        if ((b >> 3) & 1) m_view = wrap7(m_view + dir);
        else m_addr = wrap7(m_addr + dir);
      end
      5: begin m_wide = (b >> 4) & 1; m_two = (b >> 3) & 1; m_tall = m_two ? 0 : (b >> 2) & 1; end
      6: begin m_cg = b % 64; m_sel = 1; end
      default: begin m_addr = b % 128; m_sel = 0; end
    endcase
    return ST;
  endfunction

  task automatic model_edge(input int en, input int rs, input int d, input int tk);
    int ld = -1;
    if (!rst_n) begin model_reset(); return; end
    if (m_enq == 1 && en == 0) begin
      if (m_busy > 0) begin
        if (m_err < 255) m_err++;
      end else if (m_first == 1) begin
        m_first = 0; m_half = 0;
        ld = model_apply(rs, d * 16);
      end else if (m_half == 0) begin
        m_hi = d; m_half = 1;
      end else begin
        m_half = 0;
        ld = model_apply(rs, m_hi * 16 + d);
      end
    end
    if (ld > 0) m_busy = ld;
    else if (tk == 1 && m_busy > 0) m_busy--;
    m_enq = en;
  endtask

  task automatic compare_all();
    check("R13 busy", busy, m_busy > 0);
    check("R6 ddram_addr", ddram_addr, m_addr);
    check("R11 cgram_addr", cgram_addr, m_cg);
    check("R4 cg_select", cg_select, m_sel);
    check("R6 inc_mode", inc_mode, m_inc);
    check("R6 shift_mode", shift_mode, m_sh);
    check("R7 flags", {display_on, cursor_on, blink_on}, m_don * 4 + m_con * 2 + m_bon);
    check("R8 func", {wide_bus, two_lines, tall_font}, m_wide * 4 + m_two * 2 + m_tall);
    check("R10 view_offset", view_offset, m_view);
    check("R12 strobe_errs", strobe_errs, m_err);
    check("R9 peek_data", peek_data, m_mem[peek_addr]);
  endtask

  task automatic step(input logic en, input logic rs, input logic [3:0] d);
    logic tk;
    tk = (cyc % 2 == 0);
    lcd_en = en; lcd_rs = rs; lcd_d = d; us_tick = tk;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    model_edge(int'(en), int'(rs), int'(d), int'(tk));
    compare_all();
  endtask

  task automatic strobe(input logic rs, input logic [3:0] n);
    step(1'b1, rs, n); step(1'b1, rs, n); step(1'b0, rs, n); step(1'b0, rs, n);
  endtask

  task automatic send_nowait(input logic rs, input logic [7:0] b);
    strobe(rs, b[7:4]); strobe(rs, b[3:0]);
  endtask

  task automatic settle();
    while (busy) step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);
  endtask

  task automatic send(input logic rs, input logic [7:0] b);
    send_nowait(rs, b); settle();
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    peek_addr = AW'(a);
    step(1'b0, 1'b0, 4'h0);
    check(tag, peek_data, exp);
  endtask

  task automatic busy_len(input logic [7:0] b, input int ticks, input string tag);
    int n;
    send_nowait(1'b0, b);
    n = 2;
    while (busy) begin step(1'b0, 1'b0, 4'h0); n++; end
    check(tag, (n >= 2 * ticks - 2 && n <= 2 * ticks + 2), 1);
    step(1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) step(1'b0, 1'b0, 4'h0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 4'h0);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 inc_mode", inc_mode, 1);
    check("R1 wide_bus", wide_bus, 1);
    check("R1 display_on", display_on, 0);
    check("R1 strobe_errs", strobe_errs, 0);
    peek(5, 8'h20, "R1 memory fill");

    // R2 single-strobe first write
    strobe(1'b0, 4'h3);
    check("R2 busy after one strobe", busy, 1);
    settle();
    check("R2 wide_bus", wide_bus, 1);

    // R3 two-strobe pairing, R8 function set
    send(1'b0, 8'h28);
    check("R3 two_lines", two_lines, 1);
    check("R3 wide_bus", wide_bus, 0);
    send(1'b0, 8'h24);
    check("R8 tall_font N=0", tall_font, 1);
    send(1'b0, 8'h2C);
    check("R8 tall_font ignored N=1", tall_font, 0);

    // R7 display control
    send(1'b0, 8'h0D);
    check("R7 flags", {display_on, cursor_on, blink_on}, 3'b101);

    // R6 entry mode and writes
    send(1'b0, 8'h06);
    send(1'b0, 8'h80);
    send(1'b1, 8'h41);
    send(1'b1, 8'h42);
    check("R6 addr after two writes", ddram_addr, 2);
    peek(0, 8'h41, "R6 byte 0");
    peek(1, 8'h42, "R6 byte 1");
    send(1'b0, 8'h04);
    send(1'b1, 8'h43);
    check("R6 decrement", ddram_addr, 1);
    peek(2, 8'h43, "R6 byte 2");
    send(1'b0, 8'h07);
    send(1'b1, 8'h44);
    check("R6 auto shift", view_offset, 1);

    // R4 priority decode
    send(1'b0, 8'hFF);
    check("R4 0xFF is address set", ddram_addr, 7'h7F);
    send(1'b0, 8'h5F);
    check("R4 0x5F is glyph address", cgram_addr, 6'h1F);
    // R11 glyph writes
    send(1'b1, 8'h11);
    check("R11 cg step", cgram_addr, 6'h20);
    check("R11 dd addr kept", ddram_addr, 7'h7F);
    peek(8'h7F, 8'h20, "R11 memory untouched");

    // R10 cursor and view shifts
    send(1'b0, 8'h90);
    send(1'b0, 8'h14);
    check("R10 cursor right", ddram_addr, 7'h11);
    send(1'b0, 8'h10);
    check("R10 cursor left", ddram_addr, 7'h10);
    send(1'b0, 8'h18);
    check("R10 view left", view_offset, 0);
    send(1'b0, 8'h1C);
    check("R10 view right", view_offset, 1);

    // R5 busy lengths, R9 home
    busy_len(8'h0C, ST, "R5 short busy");
    send(1'b0, 8'h04);
    busy_len(8'h02, LT, "R5 long busy");
    check("R9 home addr", ddram_addr, 0);
    check("R9 home view", view_offset, 0);
    peek(0, 8'h41, "R9 home keeps memory");
    send_nowait(1'b0, 8'h00);
    check("R5 zero instruction not busy", busy, 0);
    settle();

    // R12 single refused strobe, pairing intact afterwards
    send_nowait(1'b0, 8'h90);
    strobe(1'b0, 4'hA);
    check("R12 one refused", strobe_errs, 1);
    settle();
    send(1'b0, 8'h85);
    check("R12 pairing intact", ddram_addr, 5);

    // R9 clear, R12 saturation under long busy
    send_nowait(1'b0, 8'h01);
    for (int k = 0; k < 260; k++) strobe(1'b1, 4'h7);
    check("R12 saturation", strobe_errs, 255);
    settle();
    check("R9 clear addr", ddram_addr, 0);
    check("R9 clear inc", inc_mode, 1);
    peek(0, 8'h20, "R9 cleared byte 0");
    peek(2, 8'h20, "R9 cleared byte 2");

    // R13 busy follows ticks: walk every memory byte against the model
    for (int a = 0; a < 128; a++) begin
      peek_addr = AW'(a);
      step(1'b0, 1'b0, 4'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule